// File: doc/BRIEF.md
# Integer ALU with Lookahead Adder

This block is a purely combinational integer arithmetic and logic unit for a 32-bit datapath. A 4-bit operation code picks one of ten functions: wrapping addition and subtraction in signed and unsigned flavours, the four bitwise operations (AND, OR, XOR, NOR), and signed and unsigned compare-less-than. Operands arrive already sign- or zero-extended; the block makes no immediate handling, shifting, multiplying or dividing.

A single adder serves every arithmetic function. For subtraction and both compares, the second operand is inverted and the carry-in is forced to 1, so the adder forms A + ~B + 1. The adder is built from 4-bit lookahead groups. Each group emits a group generate and a group propagate signal, and the group carries come from those two terms rather than through the bits. A carry flag and a signed overflow flag are produced next to the 32-bit result.

Top module: `alu32`

## Requirements
- R1: Codes 0 (signed add) and 1 (unsigned add) return (A + B) mod 2^32.
- R2: Codes 2 (signed subtract) and 3 (unsigned subtract) return (A - B) mod 2^32, formed as A + ~B + 1.
- R3: The overflow flag is 1 only for codes 0 and 2, and only when the two's-complement result falls outside the signed 32-bit range. It is 0 for codes 1 and 3.
- R4: For codes 0, 1, 2, 3, 10 and 11 the carry flag equals the carry out of bit 31 of the adder. For subtract and compare this is 1 when A >= B unsigned. For codes 4 to 7 the carry flag is 0.
- R5: Codes 4, 5, 6 and 7 return the bitwise A AND B, A OR B, A XOR B and NOR of A and B respectively. The overflow flag is 0 for these codes.
- R6: Code 10 (signed compare) returns 1 in bit 0 when A < B as signed numbers and 0 otherwise, with bits 31..1 zero. The answer is correct even when A - B overflows, and the overflow flag is 0.
- R7: Code 11 (unsigned compare) returns 1 in bit 0 exactly when A < B as unsigned numbers, with bits 31..1 zero. The overflow flag is 0.
- R8: Codes 8, 9, 12, 13, 14 and 15 return a zero result with both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand A |
| opb | input | 32 | Second operand B |
| op | input | 4 | Operation code |
| res | output | 32 | Result |
| carry | output | 1 | Adder carry-out for arithmetic and compare codes, else 0 |
| ovf | output | 1 | Signed overflow for codes 0 and 2, else 0 |

## Verification
Two conditions can arise together in the same evaluation. A signed subtraction can overflow at the moment the signed compare must correct its sign bit. An addition can raise carry and overflow together, as with two large negative operands. The bench applies operand pairs that straddle the signed limits, such as the most negative value against positive numbers and the most positive value against negative numbers, under every code. A behavioural model built on wide integer arithmetic judges the result and both flags each cycle. Random operands are mixed with these pairs to cover the general carry patterns.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  localparam int GW = 4;
  localparam int NG = W / GW;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_ADDU = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_SUBU = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_NOR  = 4'h7;
  localparam logic [3:0] OP_SLT  = 4'hA;
  localparam logic [3:0] OP_SLTU = 4'hB;

  logic          inv_b;
  logic [W-1:0]  bx, p, g, sum;
  logic [W:0]    c;
  logic [NG:0]   gc;
  logic [NG-1:0] gp, gg;
  logic          ovf_raw, lt_s, lt_u;

  assign inv_b = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign bx    = inv_b ? ~opb : opb;
  assign p     = opa ^ bx;
  assign g     = opa & bx;

  always_comb begin
    logic term, acc;
    c  = '0;
    gc = '0;
    gp = '0;
    gg = '0;
    gc[0] = inv_b;
    for (int j = 0; j < NG; j++) begin
      acc = 1'b0;
      for (int i = 0; i < GW; i++) begin
        term = g[j*GW+i];
        for (int m = i + 1; m < GW; m++) term = term & p[j*GW+m];
        acc = acc | term;
      end
      gg[j] = acc;
      gp[j] = &p[j*GW +: GW];
      gc[j+1] = gg[j] | (gp[j] & gc[j]);
      c[j*GW] = gc[j];
      for (int k = 1; k < GW; k++) begin
        acc = gc[j];
        for (int m = 0; m < k; m++) acc = acc & p[j*GW+m];
        for (int i = 0; i < k; i++) begin
          term = g[j*GW+i];
          for (int m = i + 1; m < k; m++) term = term & p[j*GW+m];
          acc = acc | term;
        end
        c[j*GW+k] = acc;
      end
    end
    c[W] = gc[NG];
  end

  assign sum     = p ^ c[W-1:0];
  assign ovf_raw = c[W-1] ^ c[W];
  assign lt_s    = sum[W-1] ^ ovf_raw;
  assign lt_u    = ~c[W];

  always_comb begin
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res = sum; carry = c[W]; ovf = ovf_raw;
      end
      OP_ADDU, OP_SUBU: begin
        res = sum; carry = c[W];
      end
      OP_AND: res = opa & opb;
      OP_OR:  res = opa | opb;
      OP_XOR: res = opa ^ opb;
      OP_NOR: res = ~(opa | opb);
      OP_SLT: begin
        res[0] = lt_s; carry = c[W];
      end
      OP_SLTU: begin
        res[0] = lt_u; carry = c[W];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({opa, opb, op})) begin
      if (op == OP_ADD || op == OP_ADDU)
        p_add_sum_r1: assert (res == opa + opb) else $error("add result mismatch");
      if (op == OP_SUB || op == OP_SUBU)
        p_sub_diff_r2: assert (res == opa - opb) else $error("sub result mismatch");
      if (op == OP_ADD)
        p_add_ovf_r3: assert (ovf == ((opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1])))
          else $error("add overflow mismatch");
      if (op == OP_ADDU || op == OP_SUBU)
        p_no_overflow_r3: assert (!ovf) else $error("unsigned op raised overflow");
      if (op == OP_ADD || op == OP_ADDU)
        p_add_carry_r4: assert (carry == (({1'b0, opa} + {1'b0, opb}) >> W))
          else $error("add carry mismatch");
      if (op[3:2] == 2'b01)
        p_logic_flags_r5: assert (!carry && !ovf) else $error("logic op raised a flag");
      if (op == OP_SLT)
        p_slt_r6: assert (res == {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))} && !ovf)
          else $error("signed compare mismatch");
      if (op == OP_SLTU)
        p_sltu_r7: assert (res == {{(W-1){1'b0}}, (opa < opb)} && carry == (opa >= opb))
          else $error("unsigned compare mismatch");
      if (op == 4'h8 || op == 4'h9 || op >= 4'hC)
        p_unused_zero_r8: assert (res == '0 && !carry && !ovf) else $error("unused code not quiet");
    end
  end
endmodule

// File: tb/alu32_tb.sv
module alu32_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa, opb, res;
  logic [3:0]  op;
  logic        carry, ovf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu32 u_dut (.opa(opa), .opb(opb), .op(op), .res(res), .carry(carry), .ovf(ovf));

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h1: return "R1/R3/R4";
      4'h2, 4'h3: return "R2/R3/R4";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5/R4";
      4'hA: return "R6/R4";
      4'hB: return "R7/R4";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o,
                       output logic [31:0] r, output logic cy, output logic v);
    longint sa, sb, ls;
    longint unsigned ua, ub, us;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a); ub = longint'(b);
    r = 32'h0; cy = 1'b0; v = 1'b0;
    case (o)
      4'h0, 4'h1: begin
        us = ua + ub; r = us[31:0]; cy = us[32];
        ls = sa + sb; if (o == 4'h0) v = (ls > 64'sd2147483647) || (ls < -64'sd2147483648);
      end
      4'h2, 4'h3: begin
        r = a - b; cy = (ua >= ub);
        ls = sa - sb; if (o == 4'h2) v = (ls > 64'sd2147483647) || (ls < -64'sd2147483648);
      end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: begin r = (sa < sb) ? 32'd1 : 32'd0; cy = (ua >= ub); end
      4'hB: begin r = (ua < ub) ? 32'd1 : 32'd0; cy = (ua >= ub); end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o);
    logic [31:0] er;
    logic ec, ev;
    @(posedge clk);
    #1;
    opa = a; opb = b; op = o;
    model(a, b, o, er, ec, ev);
    @(negedge clk);
    n_chk++;
    if (res !== er || carry !== ec || ovf !== ev) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
               req_of(o), o, a, b, res, carry, ovf, er, ec, ev);
    end
  endtask

  initial begin
    logic [31:0] edges [8];
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'h7FFF_FFFF;
    edges[3] = 32'h8000_0000; edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h8000_0001;
    edges[6] = 32'h7FFF_FFFE; edges[7] = 32'h5555_AAAA;
    opa = '0; opb = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero operands, add code -> zero result, no flags (R1, R3, R4)
    apply(32'h0, 32'h0, 4'h0);
    // R3/R4: carry and overflow together; R6: compare across overflowing subtraction
    apply(32'h8000_0000, 32'h8000_0000, 4'h0);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'h0);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'h1);
    apply(32'h8000_0000, 32'h0000_0001, 4'h2);
    apply(32'h8000_0000, 32'h0000_0001, 4'h3);
    apply(32'h8000_0000, 32'h0000_0001, 4'hA);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);
    apply(32'h0000_0001, 32'hFFFF_FFFF, 4'hB);
    apply(32'h1234_5678, 32'h1234_5678, 4'hB);
    // R5 logic, R8 unused codes with nonzero operands
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 4'h7);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h8);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'hE);
    // all codes on every pair of boundary operands (R1..R8)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(edges[i], edges[j], 4'(o));
    // random operands under every code
    for (int k = 0; k < 3000; k++)
      apply($urandom, $urandom, 4'($urandom % 16));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule